// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block recovers characters from an asynchronous serial line. A programmable divisor and a prescale exponent set a 16x oversampling tick. The tick counter restarts on the falling edge of each start bit. Every bit is then sampled at the centre of its cell. A character carries 7 or 8 data bits sent least significant bit first, then an optional parity bit (even or odd), then a stop bit. The serial input passes through a two-flop synchronizer before edge detection. A start bit that reads high at its centre sample counts as a glitch and is dropped.

A host reads and writes four byte-wide registers through a simple bus. Reads are combinational and take their side effects at the clock edge. The registers are: control at address 0, divisor at address 1, status at address 2 and received data at address 3.

The status flags are sticky. The error rules are:
- A frame with a framing or parity error still loads the data register, but it does not raise data-full.
- A frame that completes while data-full is still set raises overrun and is thrown away.
- While any error flag is set, no new frame is accepted.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 with reception disabled, the divisor (address 1) reads 0xFF, status (address 2) reads 0x00 and data (address 3) reads 0x00.
- R2: Control bits [5:4] hold the exponent n and address 1 holds the divisor N. One bit lasts 32·4^n·(N+1) clocks, and each bit is sampled 16·4^n·(N+1) clocks after the start bit's falling edge plus whole bit periods.
- R3: With control bit0 = 1 (enable) and bit1 = 0, eight data bits are assembled LSB first. A clean frame loads the data register and sets status bit0 (data-full).
- R4: With control bit1 = 1, seven data bits are received and data register bit 7 reads 0.
- R5: Control bit2 enables a parity bit and bit3 selects odd (1) or even (0) parity. On a mismatch, status bit3 is set and the data register is loaded, but data-full stays 0.
- R6: A low stop bit sets status bit2 (framing) and loads the data register, but data-full stays 0. Only one stop bit is checked.
- R7: A frame that completes while data-full is 1 sets status bit1 (overrun). The data register keeps its old value and data-full stays 1.
- R8: Reading the data register clears data-full. Writing 0 to status bit0 after status was read with that bit at 1 also clears it.
- R9: Each error flag clears only when status is read with that flag at 1 and a 0 is then written to that bit. A 0 written without that earlier read, or a 1 written at any time, leaves the flag unchanged.
- R10: While any of status bits 1 to 3 is set, incoming frames are ignored and the data register is unchanged.
- R11: With control bit0 = 0, incoming frames are ignored. The data register and all status flags keep their values.
- R12: A low pulse that is high again at the start-bit centre sample loads nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, side effects at the clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
Register reads are combinational, so the bench samples bus_rdata one time unit after the falling edge on which it sets the address. It does not wait for a clock. A frame's result lands a few clocks after the stop-bit centre: two synchronizer stages, then one register stage. The bench therefore holds the line idle for one more full bit period before it reads status or data. Read and write side effects take hold at the next rising edge, so each follow-up check is made in a later bus cycle.

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int CNT_W = DIV_W + 2 * ((1 << PRE_W) - 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic             ctl_en, ctl_seven, ctl_par, ctl_odd;
  logic [PRE_W-1:0] ctl_pre;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       data_q, shreg;
  logic             st_full, st_ovr, st_frm, st_par;
  logic [3:0]       seen;
  logic [2:0]       rs;
  logic [CNT_W-1:0] bcnt, lim;
  logic [3:0]       sub;
  logic [2:0]       idx;
  logic             pbit;
  st_t              state;

  wire rx_s    = rs[1];
  wire fall    = rs[2] & ~rs[1];
  wire halted  = st_ovr | st_frm | st_par;
  wire tick    = (bcnt == lim);
  wire sample  = tick && (sub == 4'd7);
  wire done    = ctl_en && (state == S_STOP) && sample;
  wire stop_bad = ~rx_s;
  wire par_bad = ctl_par && ((^shreg ^ pbit) != ctl_odd);
  wire [2:0] last = ctl_seven ? 3'd6 : 3'd7;

  wire wr_ctl  = bus_wr && bus_addr == 2'd0;
  wire wr_div  = bus_wr && bus_addr == 2'd1;
  wire wr_stat = bus_wr && bus_addr == 2'd2;
  wire rd_stat = bus_rd && bus_addr == 2'd2;
  wire rd_data = bus_rd && bus_addr == 2'd3;
  wire [3:0] clr = {4{wr_stat}} & seen & ~bus_wdata[3:0];

  assign lim = ((CNT_W'(div_q) + CNT_W'(1)) << (2 * ctl_pre + 1)) - CNT_W'(1);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = 8'({ctl_pre, ctl_odd, ctl_par, ctl_seven, ctl_en});
      2'd1:    bus_rdata = 8'(div_q);
      2'd2:    bus_rdata = {4'd0, st_par, st_frm, st_ovr, st_full};
      default: bus_rdata = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 3'b111;
    else        rs <= {rs[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_en, ctl_seven, ctl_par, ctl_odd} <= 4'd0;
      ctl_pre <= '0;
      div_q   <= '1;
    end else begin
      if (wr_ctl) begin
        ctl_en    <= bus_wdata[0];
        ctl_seven <= bus_wdata[1];
        ctl_par   <= bus_wdata[2];
        ctl_odd   <= bus_wdata[3];
        ctl_pre   <= bus_wdata[4 +: PRE_W];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bcnt  <= '0;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!ctl_en) begin
      state <= S_IDLE;
    end else if (state == S_IDLE) begin
      if (fall && !halted) begin
        state <= S_START;
        bcnt  <= '0;
        sub   <= '0;
      end
    end else begin
      bcnt <= tick ? '0 : bcnt + CNT_W'(1);
      if (tick) sub <= sub + 4'd1;
      if (sample) begin
        case (state)
          S_START: begin
            if (rx_s) state <= S_IDLE;
            else begin
              state <= S_DATA;
              idx   <= '0;
              shreg <= '0;
            end
          end
          S_DATA: begin
            shreg[idx] <= rx_s;
            if (idx == last) state <= ctl_par ? S_PAR : S_STOP;
            else             idx <= idx + 3'd1;
          end
          S_PAR: begin
            pbit  <= rx_s;
            state <= S_STOP;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      {st_par, st_frm, st_ovr, st_full} <= 4'd0;
      seen <= 4'd0;
    end else begin
      if (done && !st_full) data_q <= shreg;

      if (done && !st_full && !stop_bad && !par_bad) st_full <= 1'b1;
      else if (rd_data || clr[0])                    st_full <= 1'b0;

      if (done && st_full) st_ovr <= 1'b1;
      else if (clr[1])     st_ovr <= 1'b0;

      if (done && !st_full && stop_bad) st_frm <= 1'b1;
      else if (clr[2])                  st_frm <= 1'b0;

      if (done && !st_full && par_bad) st_par <= 1'b1;
      else if (clr[3])                 st_par <= 1'b0;

      if (rd_stat) seen <= seen | {st_par, st_frm, st_ovr, st_full};
      if (rd_data || clr[0]) seen[0] <= 1'b0;
      if (clr[1]) seen[1] <= 1'b0;
      if (clr[2]) seen[2] <= 1'b0;
      if (clr[3]) seen[3] <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       w_frm,
  input logic       w_par,
  input logic       ctl_en,
  input logic       ctl_seven,
  input logic [7:0] data_q,
  input logic       st_full,
  input logic       st_ovr,
  input logic       st_frm,
  input logic       st_par
);
  // R7
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $stable(data_q) && st_full && $past(st_full));

  // R4
  seven_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_seven && $past(ctl_seven) && !$stable(data_q)) |-> !data_q[7]);

  // R3
  clean_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_full) |-> !st_frm && !st_par && !st_ovr);

  // R9
  frm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_frm) |-> $past(bus_wr && bus_addr == 2'd2 && !w_frm));

  // R9
  par_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_par) |-> $past(bus_wr && bus_addr == 2'd2 && !w_par));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_ovr || st_frm || st_par) && !bus_wr) |=> $stable(data_q));

  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !bus_wr) |=> $stable(data_q) && $stable(st_ovr) && $stable(st_frm) && $stable(st_par));
endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .w_frm(bus_wdata[2]), .w_par(bus_wdata[3]),
  .ctl_en(ctl_en), .ctl_seven(ctl_seven), .data_q(data_q),
  .st_full(st_full), .st_ovr(st_ovr), .st_frm(st_frm), .st_par(st_par)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  serial_rx_unit i_serial_rx_unit (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drive(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input bit seven, input bit odd);
    logic [7:0] m;
    m = seven ? (d & 8'h7F) : d;
    return (^m) ^ odd;
  endfunction

  task automatic send(input logic [7:0] d, input bit seven, input bit pen, input bit odd,
                      input bit bad_par, input bit bad_stop, input int bper);
    @(negedge clk);
    drive(1'b0, bper);
    for (int i = 0; i < (seven ? 7 : 8); i++) drive(d[i], bper);
    if (pen) drive(par_of(d, seven, odd) ^ bad_par, bper);
    drive(!bad_stop, bper);
    drive(1'b1, bper);
  endtask

  function automatic logic [7:0] ctlw(input int n, input bit odd, input bit pen, input bit seven, input bit en);
    return {2'b00, 2'(n), odd, pen, seven, en};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, ed;
    int bp;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rdchk("R1 ctl", 2'd0, 8'h00);
    rdchk("R1 div", 2'd1, 8'hFF);
    rdchk("R1 status", 2'd2, 8'h00);
    rdchk("R1 data", 2'd3, 8'h00);

    bp = 32;
    wr(2'd1, 8'h00);
    // R3 R4 R5 R6 R8: randomized frames
    for (int it = 0; it < 16; it++) begin
      bit seven, pen, odd;
      int kind;
      logic [7:0] es;
      d = 8'($urandom);
      seven = 1'($urandom); pen = 1'($urandom); odd = 1'($urandom);
      kind = $urandom % 4;
      if (kind == 2 && !pen) kind = 0;
      wr(2'd0, ctlw(0, odd, pen, seven, 1'b1));
      send(d, seven, pen, odd, kind == 2, kind == 3, bp);
      ed = seven ? (d & 8'h7F) : d;
      es = (kind == 2) ? 8'h08 : (kind == 3) ? 8'h04 : 8'h01;
      rdchk(kind == 2 ? "R5 status" : kind == 3 ? "R6 status" : seven ? "R4 status" : "R3 status", 2'd2, es);
      rdchk(seven ? "R4 data" : kind == 2 ? "R5 data" : kind == 3 ? "R6 data" : "R3 data", 2'd3, ed);
      if (kind >= 2) wr(2'd2, 8'h00);
      rdchk(kind >= 2 ? "R9 cleared" : "R8 read clears", 2'd2, 8'h00);
    end

    // R2: n=1, N=2 gives 384 clocks per bit
    wr(2'd1, 8'h02);
    wr(2'd0, ctlw(1, 0, 0, 0, 1));
    rdchk("R2 ctl", 2'd0, 8'h11);
    send(8'hA5, 0, 0, 0, 0, 0, 384);
    rdchk("R2 status", 2'd2, 8'h01);
    rdchk("R2 data", 2'd3, 8'hA5);
    wr(2'd1, 8'h00);
    wr(2'd0, ctlw(0, 1, 1, 0, 1));

    // R7 then R10
    send(8'h3C, 0, 1, 1, 0, 0, bp);
    send(8'hC3, 0, 1, 1, 0, 0, bp);
    rdchk("R7 status", 2'd2, 8'h03);
    send(8'h99, 0, 1, 1, 0, 0, bp);
    rdchk("R10 status", 2'd2, 8'h03);
    rdchk("R7 data kept", 2'd3, 8'h3C);
    rdchk("R8 read clears full", 2'd2, 8'h02);
    wr(2'd2, 8'h0D);
    rdchk("R9 ovr cleared", 2'd2, 8'h00);

    // R8 write-0 clear of data-full
    send(8'h5A, 0, 1, 1, 0, 0, bp);
    rdchk("R8 full set", 2'd2, 8'h01);
    wr(2'd2, 8'hFE);
    rdchk("R8 write0 clears", 2'd2, 8'h00);
    rdchk("R8 data stays", 2'd3, 8'h5A);

    // R9 and R10 with a framing error pending
    send(8'h81, 0, 1, 1, 0, 1, bp);
    wr(2'd2, 8'h00);
    rdchk("R9 no prior read", 2'd2, 8'h04);
    wr(2'd2, 8'hFF);
    rdchk("R9 write one", 2'd2, 8'h04);
    send(8'h77, 0, 1, 1, 0, 0, bp);
    rdchk("R10 data kept", 2'd3, 8'h81);
    rdchk("R10 status", 2'd2, 8'h04);
    wr(2'd2, 8'h00);
    rdchk("R9 cleared", 2'd2, 8'h00);

    // R12 glitch
    @(negedge clk);
    drive(1'b0, 4);
    drive(1'b1, 3 * bp);
    rdchk("R12 status", 2'd2, 8'h00);
    rdchk("R12 data", 2'd3, 8'h81);

    // R11 disabled with data-full pending
    send(8'h42, 0, 1, 1, 0, 0, bp);
    wr(2'd0, ctlw(0, 1, 1, 0, 0));
    send(8'hE7, 0, 1, 1, 0, 0, bp);
    rdchk("R11 status", 2'd2, 8'h01);
    rdchk("R11 data", 2'd3, 8'h42);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule